// File: doc/BRIEF.md
# Packed 4:2:2 Luma/Chroma to RGB Pixel Converter

This block accepts a byte-wide camera stream in which luma and colour-difference samples are interleaved in groups of four bytes (blue difference, first luma, red difference, second luma). Both luma samples of a group share that group's two colour-difference samples. The block emits one 8-bit-per-channel RGB pixel for every luma byte it accepts. The colour conversion uses integer coefficients scaled by 256, and each channel is clamped to the range 0..255.

Input bytes are qualified by a valid strobe and by a line-active flag. While the line-active flag is low, no byte is accepted and the byte position returns to the start of a group, so every line begins with a blue-difference byte. The datapath is a three-register pipeline that can emit one pixel per clock. A parameter selects one of two equivalent arithmetic forms. The centred form subtracts 128 from each chroma sample before multiplying. The folded form multiplies the raw chroma and adds a precomputed constant.

Top module: `uyvy_rgb_conv`

## Requirements
- R1: Accepted bytes take the group positions 0 = U, 1 = Y0, 2 = V, 3 = Y1 in turn. The pixel for Y0 and the pixel for Y1 both use the U and V bytes of their own group.
- R2: Red output equals floor((256*Y + 359*(V-128)) / 256), clamped to 0..255.
- R3: Green output equals floor((256*Y - 183*(V-128) - 88*(U-128)) / 256), clamped to 0..255. When U = V = 128, all three channels equal Y.
- R4: Blue output equals floor((256*Y + 454*(U-128)) / 256), clamped to 0..255.
- R5: A channel result below zero gives 0, and a channel result above 255 gives 255. Luma and chroma extremes (0, 128, 255) produce no wraparound.
- R6: `pix_valid` is high for exactly one cycle per pixel. This cycle follows the third rising edge, counting as the first edge the one that samples the V byte (for the Y0 pixel) or the Y1 byte (for the Y1 pixel).
- R7: Each complete group yields exactly two pixels. A U byte never yields a pixel.
- R8: A byte presented while `line_act` is low is ignored. The next accepted byte is taken as U.
- R9: A cycle with `byte_vld` low neither advances the group position nor produces a pixel.
- R10: While `pix_valid` is low, the three colour outputs hold their previous values.
- R11: The folded-offset form (`FOLD_OFFSETS` = 1) gives results identical to the centred form for every input.
- R12: After reset, `pix_valid` is low and all colour outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Input byte qualifier |
| line_act | input | 1 | High for the duration of an active line |
| byte_in | input | PIX_W | Stream byte |
| pix_valid | output | 1 | One-cycle strobe marking a new RGB pixel |
| red | output | PIX_W | Red channel |
| green | output | PIX_W | Green channel |
| blue | output | PIX_W | Blue channel |

## Verification
Each pixel is due three edges after its triggering byte is sampled: the V byte for Y0 and the Y1 byte for Y1. Nothing is due after a U byte. The bench drives and samples on falling edges. For each pixel, its model records the due cycle as the current cycle count plus three. On every falling edge, the outputs are compared either with the pixel due in that cycle or, if none is due, with the held previous values. A second instance built in the folded form is compared against the same expectations, so the two arithmetic forms are checked against each other cycle by cycle.

// File: rtl/uyvy_rgb_pkg.sv
package uyvy_rgb_pkg;
  // fixed-point scale: coefficients are real factors times 2**FRAC
  localparam int FRAC    = 8;
  localparam int K_RV    = 359;  // red from V
  localparam int K_GV    = 183;  // green from V (subtracted)
  localparam int K_GU    = 88;   // green from U (subtracted)
  localparam int K_BU    = 454;  // blue from U

  // position of a byte inside a four-byte chroma group
  typedef enum logic [1:0] {
    PH_U  = 2'd0,
    PH_Y0 = 2'd1,
    PH_V  = 2'd2,
    PH_Y1 = 2'd3
  } byte_phase_e;
endpackage

// File: rtl/uyvy_pair_unpack.sv
module uyvy_pair_unpack
  import uyvy_rgb_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic             line_act,
  input  logic [PIX_W-1:0] byte_in,
  output logic             lane_vld,
  output logic [PIX_W-1:0] lane_y,
  output logic [PIX_W-1:0] lane_u,
  output logic [PIX_W-1:0] lane_v,
  output byte_phase_e      phase
);
  logic [PIX_W-1:0] u_hold;
  logic [PIX_W-1:0] y0_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_U;
      u_hold   <= '0;
      y0_hold  <= '0;
      lane_vld <= 1'b0;
      lane_y   <= '0;
      lane_u   <= '0;
      lane_v   <= '0;
    end else begin
      lane_vld <= 1'b0;
      if (!line_act) begin
        phase <= PH_U;
      end else if (byte_vld) begin
        case (phase)
          PH_U: begin
            u_hold <= byte_in;
            phase  <= PH_Y0;
          end
          PH_Y0: begin
            y0_hold <= byte_in;
            phase   <= PH_V;
          end
          PH_V: begin
            // first luma can only be emitted once its V is known
            lane_vld <= 1'b1;
            lane_y   <= y0_hold;
            lane_u   <= u_hold;
            lane_v   <= byte_in;
            phase    <= PH_Y1;
          end
          default: begin
            // second luma reuses the chroma latched with Y0
            lane_vld <= 1'b1;
            lane_y   <= byte_in;
            phase    <= PH_U;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/yuv_rgb_mac.sv
module yuv_rgb_mac
  import uyvy_rgb_pkg::*;
#(
  parameter int PIX_W        = 8,
  parameter int FOLD_OFFSETS = 0,
  parameter int SUM_W        = PIX_W + FRAC + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lane_vld,
  input  logic [PIX_W-1:0]        lane_y,
  input  logic [PIX_W-1:0]        lane_u,
  input  logic [PIX_W-1:0]        lane_v,
  output logic                    acc_vld,
  output logic signed [SUM_W-1:0] acc [3]
);
  localparam int MID = 1 << (PIX_W - 1);
  localparam logic signed [SUM_W-1:0] C_RV  = SUM_W'(K_RV);
  localparam logic signed [SUM_W-1:0] C_GV  = SUM_W'(K_GV);
  localparam logic signed [SUM_W-1:0] C_GU  = SUM_W'(K_GU);
  localparam logic signed [SUM_W-1:0] C_BU  = SUM_W'(K_BU);
  localparam logic signed [SUM_W-1:0] C_MID = SUM_W'(MID);

  logic signed [SUM_W-1:0] y_sc;
  logic signed [SUM_W-1:0] u_z;
  logic signed [SUM_W-1:0] v_z;
  logic signed [SUM_W-1:0] nxt [3];

  assign u_z  = $signed({{(SUM_W-PIX_W){1'b0}}, lane_u});
  assign v_z  = $signed({{(SUM_W-PIX_W){1'b0}}, lane_v});
  assign y_sc = $signed({{(SUM_W-PIX_W){1'b0}}, lane_y}) <<< FRAC;

  generate
    if (FOLD_OFFSETS == 0) begin : g_centred
      logic signed [SUM_W-1:0] u_c;
      logic signed [SUM_W-1:0] v_c;
      always_comb begin
        u_c    = u_z - C_MID;
        v_c    = v_z - C_MID;
        nxt[0] = y_sc + C_RV * v_c;
        nxt[1] = y_sc - C_GV * v_c - C_GU * u_c;
        nxt[2] = y_sc + C_BU * u_c;
      end
    end else begin : g_folded
      localparam logic signed [SUM_W-1:0] OFF_R = SUM_W'(K_RV * MID);
      localparam logic signed [SUM_W-1:0] OFF_G = SUM_W'((K_GV + K_GU) * MID);
      localparam logic signed [SUM_W-1:0] OFF_B = SUM_W'(K_BU * MID);
      always_comb begin
        nxt[0] = y_sc + C_RV * v_z - OFF_R;
        nxt[1] = y_sc - C_GV * v_z - C_GU * u_z + OFF_G;
        nxt[2] = y_sc + C_BU * u_z - OFF_B;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_vld <= 1'b0;
      for (int c = 0; c < 3; c++) acc[c] <= '0;
    end else begin
      acc_vld <= lane_vld;
      if (lane_vld) begin
        for (int c = 0; c < 3; c++) acc[c] <= nxt[c];
      end
    end
  end
endmodule

// File: rtl/rgb_sat.sv
module rgb_sat
  import uyvy_rgb_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SUM_W = PIX_W + FRAC + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_vld,
  input  logic signed [SUM_W-1:0] acc [3],
  output logic                    pix_vld,
  output logic [PIX_W-1:0]        chan [3]
);
  logic [PIX_W-1:0] clip [3];

  generate
    for (genvar c = 0; c < 3; c++) begin : g_chan
      logic signed [SUM_W-1:0] sh;
      always_comb begin
        sh = acc[c] >>> FRAC;
        if (sh[SUM_W-1])                 clip[c] = '0;
        else if (|sh[SUM_W-2:PIX_W])     clip[c] = '1;
        else                             clip[c] = sh[PIX_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_vld <= 1'b0;
      for (int c = 0; c < 3; c++) chan[c] <= '0;
    end else begin
      pix_vld <= acc_vld;
      if (acc_vld) begin
        for (int c = 0; c < 3; c++) chan[c] <= clip[c];
      end
    end
  end
endmodule

// File: rtl/uyvy_rgb_conv.sv
module uyvy_rgb_conv
  import uyvy_rgb_pkg::*;
#(
  parameter int PIX_W        = 8,
  parameter int FOLD_OFFSETS = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic             line_act,
  input  logic [PIX_W-1:0] byte_in,
  output logic             pix_valid,
  output logic [PIX_W-1:0] red,
  output logic [PIX_W-1:0] green,
  output logic [PIX_W-1:0] blue
);
  localparam int SUM_W = PIX_W + FRAC + 3;

  logic                    s1_valid;
  logic [PIX_W-1:0]        s1_y, s1_u, s1_v;
  byte_phase_e             byte_ph;
  logic                    s2_valid;
  logic signed [SUM_W-1:0] s2_acc [3];
  logic [PIX_W-1:0]        chan [3];

  uyvy_pair_unpack #(.PIX_W(PIX_W)) i_unpack (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .line_act(line_act),
    .byte_in(byte_in), .lane_vld(s1_valid), .lane_y(s1_y),
    .lane_u(s1_u), .lane_v(s1_v), .phase(byte_ph)
  );

  yuv_rgb_mac #(.PIX_W(PIX_W), .FOLD_OFFSETS(FOLD_OFFSETS), .SUM_W(SUM_W)) i_mac (
    .clk(clk), .rst(rst), .lane_vld(s1_valid), .lane_y(s1_y),
    .lane_u(s1_u), .lane_v(s1_v), .acc_vld(s2_valid), .acc(s2_acc)
  );

  rgb_sat #(.PIX_W(PIX_W), .SUM_W(SUM_W)) i_sat (
    .clk(clk), .rst(rst), .acc_vld(s2_valid), .acc(s2_acc),
    .pix_vld(pix_valid), .chan(chan)
  );

  assign red   = chan[0];
  assign green = chan[1];
  assign blue  = chan[2];
endmodule

// File: rtl/uyvy_rgb_conv_chk.sv
module uyvy_rgb_conv_chk
  import uyvy_rgb_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             byte_vld,
  input logic             line_act,
  input logic             pix_valid,
  input logic [PIX_W-1:0] red,
  input logic [PIX_W-1:0] green,
  input logic [PIX_W-1:0] blue,
  input logic             s1_valid,
  input logic [PIX_W-1:0] s1_u,
  input logic [PIX_W-1:0] s1_v,
  input byte_phase_e      byte_ph
);
  localparam logic [PIX_W-1:0] MID = PIX_W'(1 << (PIX_W - 1));

  // R6: a pixel handed to the arithmetic reaches the port two edges later
  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> ##2 pix_valid);

  // R6: no output strobe without an accepted byte three edges earlier
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(byte_vld && line_act, 3));

  // R7: a U byte never yields a pixel
  a_r7_no_pixel_for_u: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && line_act && byte_ph == PH_U) |-> ##3 !pix_valid);

  // R8: an inactive line sends the group position back to U
  a_r8_line_restart: assert property (@(posedge clk) disable iff (rst)
    !line_act |=> byte_ph == PH_U);

  // R3: neutral chroma yields equal channels
  a_r3_neutral_grey: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_u == MID && s1_v == MID) |-> ##2 (red == green && green == blue));

  // R10: colour outputs hold between pixels
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> ($stable(red) && $stable(green) && $stable(blue)));
endmodule

bind uyvy_rgb_conv uyvy_rgb_conv_chk #(.PIX_W(PIX_W)) i_chk (
  .clk(clk), .rst(rst), .byte_vld(byte_vld), .line_act(line_act),
  .pix_valid(pix_valid), .red(red), .green(green), .blue(blue),
  .s1_valid(s1_valid), .s1_u(s1_u), .s1_v(s1_v), .byte_ph(byte_ph)
);

// File: tb/test_uyvy_rgb_conv.sv
`timescale 1ns/1ps
module test_uyvy_rgb_conv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_vld = 1'b0;
  logic       line_act = 1'b0;
  logic [7:0] byte_in = 8'd0;
  logic       pv_a, pv_b;
  logic [7:0] r_a, g_a, b_a, r_b, g_b, b_b;

  always #2 clk = ~clk;

  uyvy_rgb_conv #(.PIX_W(8), .FOLD_OFFSETS(0)) i_uyvy_rgb_conv (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .line_act(line_act), .byte_in(byte_in),
    .pix_valid(pv_a), .red(r_a), .green(g_a), .blue(b_a));

  uyvy_rgb_conv #(.PIX_W(8), .FOLD_OFFSETS(1)) i_uyvy_rgb_conv_folded (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .line_act(line_act), .byte_in(byte_in),
    .pix_valid(pv_b), .red(r_b), .green(g_b), .blue(b_b));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 0;
  int q_due[$], q_r[$], q_g[$], q_b[$];
  int ex_r = 0, ex_g = 0, ex_b = 0;
  int m_ph = 0, m_u = 0, m_y0 = 0;
  int pix_exp = 0, pix_seen = 0;
  string sec = "R12";

  function automatic int clip8(int x);
    int q;
    if (x < 0) return 0;
    q = x / 256;
    return (q > 255) ? 255 : q;
  endfunction

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] cycle=%0d actual=%0d expected=%0d", rq, sec, cyc, act, exp);
    end
  endtask

  task automatic push_pix(int y, int u, int v);
    q_due.push_back(cyc + 3);
    q_r.push_back(clip8(256*y + 359*(v-128)));
    q_g.push_back(clip8(256*y - 183*(v-128) - 88*(u-128)));
    q_b.push_back(clip8(256*y + 454*(u-128)));
    pix_exp++;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  task automatic compare();
    bit due;
    due = (q_due.size() > 0) && (q_due[0] == cyc);
    if (due) begin
      void'(q_due.pop_front());
      ex_r = q_r.pop_front();
      ex_g = q_g.pop_front();
      ex_b = q_b.pop_front();
    end
    if (pv_a) pix_seen++;
    chk("R6 valid", int'(pv_a), int'(due));
    chk(due ? "R2 red"   : "R10 hold red",   int'(r_a), ex_r);
    chk(due ? "R3 green" : "R10 hold green", int'(g_a), ex_g);
    chk(due ? "R4 blue"  : "R10 hold blue",  int'(b_a), ex_b);
    chk("R11 folded valid", int'(pv_b), int'(due));
    chk("R11 folded red",   int'(r_b), ex_r);
    chk("R11 folded green", int'(g_b), ex_g);
    chk("R11 folded blue",  int'(b_b), ex_b);
  endtask

  // one falling edge: check outputs, then drive and update the model
  task automatic step(bit v, bit l, int b);
    @(negedge clk);
    compare();
    byte_vld = v;
    line_act = l;
    byte_in  = 8'(b);
    if (!rst) begin
      if (!l) m_ph = 0;
      else if (v) begin
        case (m_ph)
          0: m_u = b;
          1: m_y0 = b;
          2: push_pix(m_y0, m_u, b);
          default: push_pix(b, m_u, 0 + (q_due.size() >= 0 ? m_v_last : 0));
        endcase
        m_ph = (m_ph + 1) % 4;
      end
    end
  endtask

  int m_v_last = 0;

  task automatic group(int u, int y0, int v, int y1);
    step(1, 1, u);
    step(1, 1, y0);
    m_v_last = v;
    step(1, 1, v);
    step(1, 1, y1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    // R12: reset state
    sec = "R12";
    repeat (4) step(0, 0, 0);
    @(negedge clk);
    chk("R12 reset valid", int'(pv_a), 0);
    chk("R12 reset red", int'(r_a), 0);
    chk("R12 reset green", int'(g_a), 0);
    chk("R12 reset blue", int'(b_a), 0);
    rst = 1'b0;
    step(0, 0, 0);

    // R1: pairing of shared chroma with two luma samples
    sec = "R1";
    group(100, 50, 200, 180);
    group(30, 220, 90, 10);
    group(128, 77, 128, 140);
    step(0, 0, 0);
    step(0, 0, 0);

    // R5: luma and chroma extremes
    sec = "R5";
    foreach (q_due[i]) begin end
    for (int yi = 0; yi < 2; yi++)
      for (int ui = 0; ui < 3; ui++)
        for (int vi = 0; vi < 3; vi++) begin
          int cv[3] = '{0, 128, 255};
          group(cv[ui], yi * 255, cv[vi], 255 - yi * 255);
        end
    step(0, 0, 0);

    // R8: line drop in the middle of a group; bytes while inactive ignored
    sec = "R8";
    step(1, 1, 200);
    step(1, 1, 60);
    step(1, 0, 33);
    step(1, 0, 250);
    group(10, 90, 240, 160);
    step(1, 1, 5);
    step(0, 0, 0);
    step(1, 0, 99);
    group(250, 120, 20, 30);
    step(0, 0, 0);

    // R9: gaps in the byte strobe, random content
    sec = "R9";
    for (int n = 0; n < 600; n++) begin
      bit v;
      bit l;
      int b;
      v = ($urandom_range(0, 3) != 0);
      l = ($urandom_range(0, 40) != 0);
      b = $urandom_range(0, 255);
      if (l && v && m_ph == 2) m_v_last = b;
      step(v, l, b);
    end

    // drain and count
    sec = "R7";
    step(0, 0, 0);
    repeat (6) step(0, 0, 0);
    chk("R7 pixel count", pix_seen, pix_exp);
    summary();
    $finish;
  end
endmodule